// File: doc/BRIEF.md
# 256-bit Streaming Packet Transmitter with Two-Cycle Ready Latency

This block moves variable-length packets from an upstream valid/ready source onto a wide streaming transmit interface. The sink uses a ready latency of two cycles. The sink raises `tx_ready` in one cycle, and the transmitter may present a beat on `tx_valid` in the cycle two clocks later. Every beat that the transmitter presents in that window is taken. Each output beat carries 256 data bits together with start-of-packet and end-of-packet flags. The end-of-packet beat also carries a 2-bit count of unused 64-bit words at its top.

The upstream side gives each packet's total length in 32-bit words together with the packet's first beat. The block marks each beat as it enters and places it in a small skid FIFO. Beats still arriving when the sink withholds ready are held there. No beat is lost or repeated. When ready returns, output resumes on its own. The upstream source must keep `in_valid` high from a packet's first beat to its last, stalling only while `in_ready` is low. Given that, the output never pauses inside a packet except where the sink's latency-adjusted ready is low.

Top module: `txs_stream_tx`

## Requirements
- R1: `tx_valid` is high in a cycle only if `tx_ready` was high two cycles earlier. As a result, `tx_valid` is low no later than two cycles after `tx_ready` falls.
- R2: After a start-of-packet beat and before its end-of-packet beat, `tx_valid` is high in every cycle whose `tx_ready` two cycles earlier was high. Output therefore resumes within two cycles of ready returning, given a contiguous upstream packet.
- R3: Output beats appear in the order accepted upstream, each exactly once, with `tx_data` equal to the accepted `in_data`.
- R4: `tx_sop` is 1 on the first beat of each packet only, and `tx_eop` is 1 on the last beat only. A packet of 8 or fewer dwords is one beat with both flags set.
- R5: On an end-of-packet beat with r dwords in use (1..8), `tx_empty` = floor((8 - r) / 2). The values 0, 1, 2 and 3 mean that bits [255:0], [191:0], [127:0] and [63:0] hold data. Beat k (from 0) of a packet of L dwords starts at dword 8k.
- R6: `tx_empty` is 0 on every beat that is not an end-of-packet beat.
- R7: `in_ready` is 1 exactly when the skid FIFO holds fewer than DEPTH beats. A beat transfers upstream on `in_valid && in_ready`. `in_len` is sampled only with a packet's first beat and is ignored on later beats.
- R8: A synchronous active-high `rst` clears the output valid, the skid FIFO, the ready pipeline and the packet position. During reset `tx_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream beat present |
| in_ready | output | 1 | Skid FIFO can take a beat |
| in_data | input | 256 | Upstream beat data, dword 0 in bits [31:0] |
| in_len | input | 10 | Packet length in dwords, read with the first beat (nonzero) |
| tx_ready | input | 1 | Sink ready, acting two cycles later |
| tx_valid | output | 1 | Beat presented and taken |
| tx_sop | output | 1 | First beat of a packet |
| tx_eop | output | 1 | Last beat of a packet |
| tx_empty | output | 2 | Unused upper qwords on the last beat |
| tx_data | output | 256 | Beat data |

## Verification
The bench changes the sink's ready pattern through several phases. These are single-cycle drops, a pseudo-random pattern, and long low stretches that fill the FIFO and pull `in_ready` low. A design whose latency was one cycle off would present a beat while the sink is still blind to it, or would stall mid-packet after ready returned. Packet lengths of 1 to 64 dwords reach every empty code and single-beat packets. A wrong empty formula, or a wrong split of start and end flags, shows up on those beats. Later beats carry a junk `in_len`, so a formatter that reloaded the length on those beats would corrupt the empty count. A FIFO that dropped or repeated a beat under backpressure would break the in-order comparison of the data.

// File: rtl/txs_pkg.sv
package txs_pkg;
   // Ready latency of the sink side; the interface behaviour is built on this value.
   localparam int unsigned TXS_RDY_LAT = 2;

   typedef struct packed {
      logic sop;
      logic eop;
   } txs_mark_t;
endpackage

// File: rtl/txs_rdy_pipe.sv
module txs_rdy_pipe #(
   parameter int unsigned LAT = 2
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           rdy_i,
   output logic [LAT-1:0] tap_o
);
   genvar gi;
   generate
      for (gi = 0; gi < LAT; gi++) begin : g_stage
         if (gi == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (rst) tap_o[gi] <= 1'b0;
               else     tap_o[gi] <= rdy_i;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (rst) tap_o[gi] <= 1'b0;
               else     tap_o[gi] <= tap_o[gi-1];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/txs_fmt.sv
module txs_fmt
   import txs_pkg::*;
#(
   parameter int unsigned DATA_W  = 256,
   parameter int unsigned LEN_W   = 10,
   parameter int unsigned EMPTY_W = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               take_i,
   input  logic [LEN_W-1:0]   len_i,
   output txs_mark_t          mark_o,
   output logic [EMPTY_W-1:0] empty_o
);
   localparam int unsigned DPB = DATA_W / 32;

   logic             mid_q;
   logic [LEN_W-1:0] rem_q;
   logic [LEN_W-1:0] rem_cur;
   logic [LEN_W-1:0] gap;
   logic             last;

   always_comb begin
      rem_cur    = mid_q ? rem_q : len_i;
      last       = (rem_cur <= LEN_W'(DPB));
      gap        = LEN_W'(DPB) - rem_cur;
      mark_o.sop = !mid_q;
      mark_o.eop = last;
      empty_o    = last ? EMPTY_W'(gap >> 1) : '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mid_q <= 1'b0;
         rem_q <= '0;
      end else if (take_i) begin
         mid_q <= !last;
         rem_q <= last ? '0 : rem_cur - LEN_W'(DPB);
      end
   end

   AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
      (take_i && !mid_q) |-> (len_i != '0)); // R7
endmodule

// File: rtl/txs_skid.sv
module txs_skid #(
   parameter int unsigned W     = 260,
   parameter int unsigned DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push_i,
   input  logic [W-1:0] wdata_i,
   input  logic         pop_i,
   output logic [W-1:0] rdata_o,
   output logic         full_o,
   output logic         avail_o
);
   localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW   = $clog2(DEPTH + 1);
   localparam bit          POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
   logic [CW-1:0] cnt_q;

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_q + 1'b1;
         assign rd_nxt = rd_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
         assign rd_nxt = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
   endgenerate

   assign rdata_o = mem[rd_q];
   assign full_o  = (cnt_q == CW'(DEPTH));
   assign avail_o = (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (push_i) mem[wr_q] <= wdata_i;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_i) wr_q <= wr_nxt;
         if (pop_i)  rd_q <= rd_nxt;
         if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
         else if (!push_i && pop_i) cnt_q <= cnt_q - 1'b1;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      push_i |-> (cnt_q < CW'(DEPTH))); // R7
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      pop_i |-> (cnt_q != '0)); // R3
endmodule

// File: rtl/txs_stream_tx.sv
module txs_stream_tx
   import txs_pkg::*;
#(
   parameter int unsigned DATA_W  = 256,
   parameter int unsigned LEN_W   = 10,
   parameter int unsigned DEPTH   = 4,
   parameter int unsigned EMPTY_W = $clog2(DATA_W / 64)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [DATA_W-1:0]  in_data,
   input  logic [LEN_W-1:0]   in_len,
   input  logic               tx_ready,
   output logic               tx_valid,
   output logic               tx_sop,
   output logic               tx_eop,
   output logic [EMPTY_W-1:0] tx_empty,
   output logic [DATA_W-1:0]  tx_data
);
   localparam int unsigned RL = TXS_RDY_LAT;
   localparam int unsigned EW = DATA_W + 2 + EMPTY_W;

   generate
      if (DATA_W < 128 || (DATA_W % 64) != 0) begin : g_bad_width
         $error("txs_stream_tx: DATA_W must be a multiple of 64, at least 128");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("txs_stream_tx: DEPTH must be at least 2");
      end
      if (LEN_W <= $clog2(DATA_W / 32)) begin : g_bad_len
         $error("txs_stream_tx: LEN_W too narrow for one beat");
      end
      if (EMPTY_W != $clog2(DATA_W / 64)) begin : g_bad_empty
         $error("txs_stream_tx: EMPTY_W must match DATA_W");
      end
      if (RL < 2) begin : g_bad_lat
         $error("txs_stream_tx: ready latency below 2 not supported");
      end
   endgenerate

   logic [RL-1:0]      rdy_tap;
   txs_mark_t          in_mark, out_mark;
   logic [EMPTY_W-1:0] in_empty, out_empty;
   logic [DATA_W-1:0]  out_data;
   logic               push, pop, full, avail;
   logic               in_pkt;

   assign in_ready = !full;
   assign push     = in_valid && in_ready;
   // Launch one cycle ahead so the registered valid lines up with the latency.
   assign pop      = rdy_tap[RL-2] && avail;

   txs_rdy_pipe #(.LAT(RL)) u_rdy (
      .clk   (clk),
      .rst   (rst),
      .rdy_i (tx_ready),
      .tap_o (rdy_tap)
   );

   txs_fmt #(.DATA_W(DATA_W), .LEN_W(LEN_W), .EMPTY_W(EMPTY_W)) u_fmt (
      .clk     (clk),
      .rst     (rst),
      .take_i  (push),
      .len_i   (in_len),
      .mark_o  (in_mark),
      .empty_o (in_empty)
   );

   txs_skid #(.W(EW), .DEPTH(DEPTH)) u_skid (
      .clk     (clk),
      .rst     (rst),
      .push_i  (push),
      .wdata_i ({in_mark, in_empty, in_data}),
      .pop_i   (pop),
      .rdata_o ({out_mark, out_empty, out_data}),
      .full_o  (full),
      .avail_o (avail)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_valid <= 1'b0;
         tx_sop   <= 1'b0;
         tx_eop   <= 1'b0;
         tx_empty <= '0;
      end else begin
         tx_valid <= pop;
         if (pop) begin
            tx_sop   <= out_mark.sop;
            tx_eop   <= out_mark.eop;
            tx_empty <= out_empty;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (pop) tx_data <= out_data;
   end

   always_ff @(posedge clk) begin
      if (rst)           in_pkt <= 1'b0;
      else if (tx_valid) in_pkt <= !tx_eop;
   end

   AST_VALID_NEEDS_RDY: assert property (@(posedge clk) disable iff (rst)
      tx_valid |-> rdy_tap[RL-1]); // R1
   AST_RDY_DROP: assert property (@(posedge clk) disable iff (rst)
      !tx_ready |-> ##2 !tx_valid); // R1
   AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
      (in_pkt && rdy_tap[RL-1]) |-> tx_valid); // R2
   AST_SOP_OPENS: assert property (@(posedge clk) disable iff (rst)
      (tx_valid && tx_sop) |-> !in_pkt); // R4
   AST_CONT_INSIDE: assert property (@(posedge clk) disable iff (rst)
      (tx_valid && !tx_sop) |-> in_pkt); // R4
   AST_EMPTY_ONLY_EOP: assert property (@(posedge clk) disable iff (rst)
      (tx_valid && !tx_eop) |-> (tx_empty == '0)); // R6
endmodule

// File: tb/txs_stream_tx_test.sv
module txs_stream_tx_test;
   localparam int CLK_P  = 10;
   localparam int DATA_W = 256;
   localparam int LEN_W  = 10;
   localparam int DEPTH  = 4;
   localparam int NPKT   = 120;
   localparam int LIMIT  = 20000;

   logic              clk = 1'b0;
   logic              rst;
   logic              in_valid;
   logic              in_ready;
   logic [DATA_W-1:0] in_data;
   logic [LEN_W-1:0]  in_len;
   logic              tx_ready;
   logic              tx_valid, tx_sop, tx_eop;
   logic [1:0]        tx_empty;
   logic [DATA_W-1:0] tx_data;

   int vecs  = 0;
   int fails = 0;

   txs_stream_tx #(.DATA_W(DATA_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) uut (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_data  (in_data),
      .in_len   (in_len),
      .tx_ready (tx_ready),
      .tx_valid (tx_valid),
      .tx_sop   (tx_sop),
      .tx_eop   (tx_eop),
      .tx_empty (tx_empty),
      .tx_data  (tx_data)
   );

   always #(CLK_P / 2) clk = ~clk;

   function automatic int pkt_len(int i);
      return (i < 16) ? i + 1 : 1 + ((i * 37 + 5) % 64);
   endfunction

   function automatic logic [DATA_W-1:0] beat_data(int i, int b);
      logic [DATA_W-1:0] d;
      for (int w = 0; w < DATA_W / 32; w++)
         d[w*32 +: 32] = {i[11:0], b[11:0], w[7:0]};
      return d;
   endfunction

   task automatic chk(bit ok, string req, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
      vecs++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   logic [DATA_W-1:0] q_data [$];
   bit                q_sop  [$];
   bit                q_eop  [$];
   logic [1:0]        q_emp  [$];

   initial begin
      int  pi, bi, idle, cnt, k, nb, len, rem, done_cnt;
      bit  r1, r2, inpkt, rv;
      logic [15:0] lfsr;
      logic [DATA_W-1:0] ed;
      bit es, ee;
      logic [1:0] em;

      pi = 0; bi = 0; idle = 0; cnt = 0; done_cnt = 0;
      r1 = 0; r2 = 0; inpkt = 0; lfsr = 16'hACE1;
      rst = 1'b1; in_valid = 1'b0; in_data = '0; in_len = '0; tx_ready = 1'b1;
      repeat (3) @(negedge clk);
      // R8: reset state
      chk(tx_valid == 1'b0, "R8", "tx_valid in reset", DATA_W'(tx_valid), '0);
      chk(in_ready == 1'b1, "R8", "in_ready in reset", DATA_W'(in_ready), 1);
      tx_ready = 1'b0;
      rst = 1'b0;

      for (k = 0; k < LIMIT; k++) begin
         @(negedge clk);
         // R1: valid only when ready two cycles back
         chk(!(tx_valid && !r2), "R1", "valid without latency ready", DATA_W'(tx_valid), DATA_W'(r2));
         // R2: no gap inside a packet
         chk(!(inpkt && r2 && !tx_valid), "R2", "gap mid-packet", DATA_W'(tx_valid), 1);
         if (tx_valid) begin
            if (q_data.size() == 0) begin
               chk(1'b0, "R3", "beat with none expected", tx_data, '0);
            end else begin
               ed = q_data.pop_front(); es = q_sop.pop_front();
               ee = q_eop.pop_front();  em = q_emp.pop_front();
               chk(tx_data == ed, "R3", "data", tx_data, ed);
               chk(tx_sop == es && tx_eop == ee, "R4", "sop/eop",
                   DATA_W'({tx_sop, tx_eop}), DATA_W'({es, ee}));
               chk(tx_empty == em, ee ? "R5" : "R6", "empty", DATA_W'(tx_empty), DATA_W'(em));
               inpkt = !tx_eop;
            end
            cnt--;
         end
         // R7: ready reflects FIFO room
         chk(in_ready == (cnt < DEPTH), "R7", "in_ready", DATA_W'(in_ready), DATA_W'(cnt < DEPTH));

         // sink ready pattern
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (k < 200)       rv = 1'b1;
         else if (k < 600)  rv = (k % 3) != 0;
         else if (k < 1000) rv = lfsr[0];
         else if (k < 1400) rv = ((k / 9) % 2) == 0;
         else               rv = 1'b1;
         r2 = r1; r1 = rv; tx_ready = rv;

         // upstream driver, contiguous within a packet
         if (pi < NPKT && idle == 0) begin
            len = pkt_len(pi);
            nb = (len + 7) / 8;
            in_valid = 1'b1;
            in_data = beat_data(pi, bi);
            // R7: junk length on later beats must be ignored
            in_len = (bi == 0) ? LEN_W'(len) : LEN_W'((k * 13) % 1024);
            if (in_ready) begin
               rem = len - 8 * bi;
               q_data.push_back(beat_data(pi, bi));
               q_sop.push_back(bi == 0);
               q_eop.push_back(bi == nb - 1);
               q_emp.push_back((bi == nb - 1) ? 2'((8 - rem) / 2) : 2'd0);
               cnt++;
               bi++;
               if (bi == nb) begin
                  bi = 0;
                  pi++;
                  idle = (pi % 4 == 3) ? 2 : 0;
               end
            end
         end else begin
            in_valid = 1'b0;
            in_data = '0;
            in_len = '0;
            if (idle > 0) idle--;
         end

         if (pi == NPKT && q_data.size() == 0) begin
            done_cnt++;
            if (done_cnt > 4) break;
         end
      end

      if (k >= LIMIT) begin
         vecs++; fails++;
         $display("FAIL R3 watchdog: actual %0d beats pending expected 0", q_data.size());
      end
      chk(cnt == 0, "R3", "all beats delivered", DATA_W'(cnt), '0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end
endmodule